// File: doc/BRIEF.md
# Switch-Hook Detect Debounce Filter

This block cleans up the switch-hook detect inputs of a group of subscriber line channels. Each channel's raw detect level is sampled once per 8 kHz frame tick. A per-channel stability counter advances on a 1 kHz tick and restarts whenever a new sample differs from the one before it. The filtered bit that goes to the rest of the chip follows the sampled level only after that level has held for the programmed number of milliseconds. At all other times the filtered bit keeps its last value.

All channels share one 4-bit period setting, covering 0 to 15 ms. Each channel has its own sampler, counter and output hold stage, and these are built in a generate loop. The frame and millisecond ticks come from outside as single-cycle enables in the block's clock domain. With a period of 0 the hold stage is always open, so the filtered bit follows each new sample.

Top module: `hook_debounce`

## Requirements
- R1: While rst_ni is low, and after reset until a change has been filtered, every bit of det_o is 0. The internal sample, the counter and the output also clear to 0.
- R2: raw_i is captured only in a cycle where fs_tick_i is 1. A level on raw_i that comes and goes between two frame ticks has no effect on det_o.
- R3: A frame tick whose captured raw bit differs from the channel's stored sample clears that channel's stability counter.
- R4: The stability counter advances by one on each ms_tick_i that arrives while it is below period_i. It stops at period_i and never wraps.
- R5: When the counter reaches period_i, det_o for that channel takes the stored sample on the next clock edge. With period P > 0, a level that stays stable appears on det_o between P-1 and P ms after the frame tick that captured it.
- R6: While the counter is below period_i, det_o for that channel holds its value.
- R7: With period_i = 0, det_o follows each new sample. It updates two clock edges after the frame tick that captured the sample.
- R8: Channels are independent. Activity on one bit of raw_i never changes the counter or det_o of another channel, and all channels use the same period_i.
- R9: If a changed sample and a ms tick fall in the same cycle, the counter clear wins and the counter is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| raw_i | input | NUM_CH | Raw detect level per channel |
| fs_tick_i | input | 1 | 8 kHz frame sample enable, one cycle wide |
| ms_tick_i | input | 1 | 1 kHz counter enable, one cycle wide |
| period_i | input | PERIOD_W | Debounce period in ms, shared by all channels |
| det_o | output | NUM_CH | Debounced detect level per channel |

## Verification
The stored sample changes at the edge where fs_tick_i is seen, and the counter clears at that same edge. det_o can move no earlier than the edge after the counter meets period_i. This puts a period-0 update two edges after the frame tick, and a period-P update one edge after the P-th millisecond tick that follows the last change. The bench drives its inputs on falling edges and updates a behavioural model on rising edges. It compares every channel of det_o at each falling edge, so each result is checked in exactly the cycle it is due. Directed checks are placed a known number of cycles after the stimulus, with an added margin of whole tick periods.

// File: rtl/hook_debounce_pkg.sv
package hook_debounce_pkg;
  localparam int unsigned DEF_NUM_CH   = 4;
  localparam int unsigned DEF_PERIOD_W = 4;
endpackage

// File: rtl/dbc_sampler.sv
module dbc_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic fs_i,
  output logic samp_o,
  output logic chg_o
);
  logic samp_q;

  assign chg_o  = fs_i && (raw_i != samp_q);
  assign samp_o = samp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   samp_q <= 1'b0;
    else if (fs_i) samp_q <= raw_i;
  end

  // R2: sample moves only on a frame tick
  p_sample_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fs_i |=> $stable(samp_o));
  // R3: a flagged change really flips the stored sample
  p_change_flips_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |=> samp_o != $past(samp_o));
endmodule

// File: rtl/dbc_counter.sv
module dbc_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (tick_i && cnt_q < limit_i) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q >= limit_i);

  // R3 / R9: clear wins over a simultaneous tick
  p_clear_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  // R4: no wrap back to zero without a clear
  p_no_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !clr_i) |=> cnt_q != '0);
  // R4: counter idles between ticks
  p_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dbc_hold.sv
module dbc_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= 1'b0;
    else if (en_i) q_o <= d_i;
  end

  // R6: output held while the count is short
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));
  // R5: output takes the sample once the count is met
  p_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> q_o == $past(d_i));
endmodule

// File: rtl/hook_debounce.sv
module hook_debounce
  import hook_debounce_pkg::*;
#(
  parameter int unsigned NUM_CH   = DEF_NUM_CH,
  parameter int unsigned PERIOD_W = DEF_PERIOD_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_CH-1:0]   raw_i,
  input  logic                fs_tick_i,
  input  logic                ms_tick_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic [NUM_CH-1:0]   det_o
);
  logic [NUM_CH-1:0] samp, chg, done;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dbc_sampler u_samp (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw_i[c]),
      .fs_i  (fs_tick_i),
      .samp_o(samp[c]),
      .chg_o (chg[c])
    );

    dbc_counter #(.W(PERIOD_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (chg[c]),
      .tick_i (ms_tick_i),
      .limit_i(period_i),
      .done_o (done[c])
    );

    dbc_hold u_hold (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (done[c]),
      .d_i   (samp[c]),
      .q_o   (det_o[c])
    );
  end

  // R7: zero period keeps every hold stage open
  p_zero_open_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i == '0) |-> (done == '1));
  // R1: output is clear in the first cycle after reset
  p_reset_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |=> det_o == '0);
endmodule

// File: tb/tb_hook_debounce.sv
module tb_hook_debounce;
  localparam int NCH = 4;
  localparam int FS_DIV = 8;
  localparam int MS_DIV = 64;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] raw = '0;
  logic           fs_tick = 1'b0, ms_tick = 1'b0;
  logic [3:0]     period = 4'd0;
  logic [NCH-1:0] det;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string tag = "R1";
  int m_samp[NCH], m_cnt[NCH], m_det[NCH];
  bit finished = 0;

  always #2 clk = ~clk;

  hook_debounce #(.NUM_CH(NCH), .PERIOD_W(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .raw_i(raw), .fs_tick_i(fs_tick),
    .ms_tick_i(ms_tick), .period_i(period), .det_o(det)
  );

  // tick generator, driven on the falling edge
  always @(negedge clk) begin
    cyc++;
    fs_tick <= (cyc % FS_DIV == 0);
    ms_tick <= (cyc % MS_DIV == 0);
  end

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin m_samp[c] = 0; m_cnt[c] = 0; m_det[c] = 0; end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        int p, new_cnt;
        p = period;
        if (m_cnt[c] >= p) m_det[c] = m_samp[c];
        new_cnt = m_cnt[c];
        if (fs_tick && raw[c] != m_samp[c]) new_cnt = 0;
        else if (ms_tick && new_cnt < p) new_cnt = new_cnt + 1;
        m_cnt[c] = new_cnt;
        if (fs_tick) m_samp[c] = raw[c];
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      for (int c = 0; c < NCH; c++) begin
        n_cmp++;
        if (det[c] !== m_det[c][0]) begin
          n_bad++;
          $display("FAIL %s ch%0d t=%0t det=%b expected=%0d", tag, c, $time, det[c], m_det[c]);
        end
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_det(input string req, input logic [NCH-1:0] exp);
    n_cmp++;
    if (det !== exp) begin
      n_bad++;
      $display("FAIL %s directed det=%b expected=%b", req, det, exp);
    end
  endtask

  task automatic wait_after_fs();
    do @(negedge clk); while (cyc % FS_DIV != 2);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    run(5);
    expect_det("R1", '0);
    @(negedge clk) rst_n = 1'b1;
    run(3);
    expect_det("R1", '0);

    // R2: a short pulse between frame ticks is ignored
    tag = "R2"; period = 4'd3;
    wait_after_fs();
    raw[0] = 1'b1; run(3); raw[0] = 1'b0;
    run(6 * MS_DIV);
    expect_det("R2", '0);

    // R5: stable level passes after the period
    tag = "R5";
    raw[0] = 1'b1;
    run(4 * MS_DIV + 2 * FS_DIV);
    expect_det("R5", 4'b0001);

    // R3 / R6: chatter faster than the period keeps the output held
    tag = "R3";
    for (int i = 0; i < 20; i++) begin
      raw[1] = ~raw[1];
      run(MS_DIV + 24);
    end
    raw[1] = 1'b0;
    tag = "R6";
    run(MS_DIV);
    expect_det("R6", 4'b0001);
    run(5 * MS_DIV);

    // R4: long stable hold, then a longer period
    tag = "R4";
    raw[2] = 1'b1;
    run(20 * MS_DIV);
    expect_det("R4", 4'b0101);
    period = 4'd15;
    raw[2] = 1'b0;
    run(10 * MS_DIV);
    expect_det("R4", 4'b0101);
    run(7 * MS_DIV);
    expect_det("R4", 4'b0001);

    // R7: zero period, output follows samples
    tag = "R7"; period = 4'd0;
    raw = 4'b1010;
    run(2 * FS_DIV + 2);
    expect_det("R7", 4'b1010);
    for (int i = 0; i < 16; i++) begin
      raw = raw ^ 4'(i + 1);
      run(FS_DIV * (1 + i % 3) + i % 5);
    end
    run(2 * FS_DIV + 2);
    expect_det("R7", raw);

    // R8: one channel chatters, the others settle independently
    tag = "R8"; period = 4'd2;
    raw = 4'b0110;
    for (int i = 0; i < 12; i++) begin
      raw[3] = ~raw[3];
      run(MS_DIV / 2);
    end
    raw[3] = 1'b0;
    run(3 * MS_DIV + 2 * FS_DIV);
    expect_det("R8", 4'b0110);

    // R9: changes aligned with ms ticks (both ticks share every 64th cycle)
    tag = "R9"; period = 4'd1;
    for (int i = 0; i < 8; i++) begin
      do @(negedge clk); while (cyc % MS_DIV != MS_DIV - 1);
      raw[0] = ~raw[0];
      run(MS_DIV / 2);
    end
    run(3 * MS_DIV);
    expect_det("R9", {2'b01, 1'b1, raw[0]});

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule